// File: doc/BRIEF.md
# Single-Bus Register Datapath with Step Sequencer

This block holds eight 4-bit general registers that all sit on one shared 4-bit bus. An operand latch A, an adder and a rotate-right barrel shifter feed a result latch C. Every transfer between these parts goes over the bus, and in each time step only one source drives it. A requester hands the block one command at a time: register add, register rotate-right, or load of an immediate nibble. A small sequencer then steps through the command and raises the output-enable, load and shifter-select controls in the right order.

An add takes three bus steps. The first source goes into A. A plus the second source goes into C. C then goes into the destination register. A rotate takes two steps. The source passes through the shifter into C, and C then goes into the destination. An immediate load takes one step, in which the external nibble drives the bus and the destination loads it. `busy` marks the steps of a running command, and `done` pulses once after the last one. A combinational read port lets the requester inspect any register.

Top module: `busdp_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, all eight registers, the A and C latches, `busy` and `done` go to zero.
- R2: Op code 2 (load immediate) writes `cmd_imm` into register `cmd_dst`, with `busy` high for exactly 1 cycle.
- R3: Op code 0 (add) writes (R[`cmd_src_a`] + R[`cmd_src_b`]) mod 16 into R[`cmd_dst`], with `busy` high for exactly 3 cycles. The carry is discarded.
- R4: Op code 1 (rotate) writes R[`cmd_src_a`] rotated right by `cmd_rot` into R[`cmd_dst`]. Written MSB first, select 0 gives i3 i2 i1 i0, 1 gives i0 i3 i2 i1, 2 gives i1 i0 i3 i2, and 3 gives i2 i1 i0 i3.
- R5: A rotate command keeps `busy` high for exactly 2 cycles.
- R6: A command changes only its destination register. Every other register keeps its value.
- R7: A command presented while `busy` is high is ignored and does not change any register.
- R8: `done` is high for exactly one cycle, in the cycle right after the last step of a command, and `busy` is low in that cycle.
- R9: Op code 3 is reserved. It is never accepted: `busy` and `done` stay low and no register changes.
- R10: At most one source drives the shared bus in any cycle.
- R11: A command may name the same register as source and destination. The add case R[d] = R[d] + R[d] gives 2·R[d] mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; accepted only when idle |
| cmd_op | input | 2 | 0 add, 1 rotate, 2 load immediate, 3 reserved |
| cmd_src_a | input | 3 | First source register index |
| cmd_src_b | input | 3 | Second source register index (add only) |
| cmd_dst | input | 3 | Destination register index |
| cmd_rot | input | 2 | Rotate-right amount (rotate only) |
| cmd_imm | input | 4 | Immediate nibble (load only) |
| rd_sel | input | 3 | Read port register index |
| rd_data | output | 4 | Read port data, combinational |
| busy | output | 1 | A command is being stepped |
| done | output | 1 | One-cycle pulse after a command's final step |

## Verification
On every cycle, assertions check the following:
- the bus has at most one driver;
- at most one register load strobe is active;
- C receives A plus the bus on an add step;
- a rotate into C keeps the number of set bits;
- the latched command is held while busy;
- `done` lasts one cycle and follows a busy step.

Only the bench scenarios can show the rest, because they need the register contents before and after a command:
- the values written to each destination;
- the exact step count of each command;
- that every non-destination register is untouched;
- that commands during busy, and the reserved op code, leave all registers unchanged.

// File: rtl/busdp_pkg.sv
// Shared types for the single-bus datapath.
// Assumes: the command op code is two bits wide.
package busdp_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_ROR = 2'd1,
        OP_LDI = 2'd2,
        OP_RSV = 2'd3
    } busdp_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADD1,
        ST_ADD2,
        ST_ADD3,
        ST_ROT1,
        ST_ROT2,
        ST_LDI1
    } busdp_state_e;

endpackage

// File: rtl/busdp_regfile.sv
// Bank of N general registers on a shared bus.
// Each register has its own load strobe from the bus and its own output enable.
// The enabled outputs are OR-merged into one bus contribution.
// Assumes: the caller keeps at most one enable and at most one load active.
module busdp_regfile #(
    parameter int W = 4,
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ld,
    input  logic [N-1:0]  oe,
    input  logic [W-1:0]  bus_in,
    output logic [W-1:0]  bus_drv,
    input  logic [IW-1:0] rd_sel,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] q [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // Register g: clear on reset, capture the bus only when its strobe is set.
        always_ff @(posedge clk) begin
            if (!rst_n)     q[g] <= '0;
            else if (ld[g]) q[g] <= bus_in;
        end
    end

    // Merge the enabled register outputs onto the bus.
    always_comb begin
        bus_drv = '0;
        for (int i = 0; i < N; i++)
            if (oe[i]) bus_drv = bus_drv | q[i];
    end

    // Read port for the requester.
    assign rd_data = q[rd_sel];

    // R6: only one register may load in a step.
    p_single_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld));
endmodule

// File: rtl/busdp_rotator.sv
// Combinational rotate-right barrel shifter.
// Output bit i takes input bit (i + sel) mod W.
// Assumes: W is a power of two.
module busdp_rotator #(
    parameter int W = 4,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] sel,
    output logic [W-1:0]  dout
);
    // Route each output bit from its rotated source bit.
    always_comb begin
        for (int i = 0; i < W; i++)
            dout[i] = din[(i + int'(sel)) % W];
    end
endmodule

// File: rtl/busdp_sequencer.sv
// Step sequencer for the single-bus datapath.
// Accepts one command while idle, latches it, and raises the bus, latch and
// register controls step by step. done pulses in the cycle after the last step.
// Assumes: op code 3 is reserved and is never accepted.
module busdp_sequencer
    import busdp_pkg::*;
#(
    parameter int W = 4,
    parameter int N = 8,
    localparam int IW = $clog2(N),
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [IW-1:0] cmd_src_a,
    input  logic [IW-1:0] cmd_src_b,
    input  logic [IW-1:0] cmd_dst,
    input  logic [SW-1:0] cmd_rot,
    input  logic [W-1:0]  cmd_imm,
    output logic [N-1:0]  reg_oe,
    output logic [N-1:0]  reg_ld,
    output logic          a_ld,
    output logic          c_ld,
    output logic          c_oe,
    output logic          x_oe,
    output logic          c_from_rot,
    output logic [SW-1:0] rot_sel,
    output logic [W-1:0]  imm_out,
    output logic          busy,
    output logic          done
);
    busdp_state_e  state;
    logic [IW-1:0] src_a_q, src_b_q, dst_q;
    logic [SW-1:0] rot_q;
    logic [W-1:0]  imm_q;
    logic          last_step;

    assign last_step = (state == ST_ADD3) || (state == ST_ROT2) || (state == ST_LDI1);

    // Advance the step state and latch a new command only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            src_a_q <= '0;
            src_b_q <= '0;
            dst_q   <= '0;
            rot_q   <= '0;
            imm_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cmd_valid && busdp_op_e'(cmd_op) != OP_RSV) begin
                    src_a_q <= cmd_src_a;
                    src_b_q <= cmd_src_b;
                    dst_q   <= cmd_dst;
                    rot_q   <= cmd_rot;
                    imm_q   <= cmd_imm;
                    case (busdp_op_e'(cmd_op))
                        OP_ADD:  state <= ST_ADD1;
                        OP_ROR:  state <= ST_ROT1;
                        default: state <= ST_LDI1;
                    endcase
                end
                ST_ADD1: state <= ST_ADD2;
                ST_ADD2: state <= ST_ADD3;
                ST_ROT1: state <= ST_ROT2;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Raise done for one cycle after the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last_step;
    end

    // Decode the control signals for the current step.
    always_comb begin
        reg_oe     = '0;
        reg_ld     = '0;
        a_ld       = 1'b0;
        c_ld       = 1'b0;
        c_oe       = 1'b0;
        x_oe       = 1'b0;
        c_from_rot = 1'b0;
        rot_sel    = '0;
        case (state)
            ST_ADD1: begin reg_oe = N'(1) << src_a_q; a_ld = 1'b1; end
            ST_ADD2: begin reg_oe = N'(1) << src_b_q; c_ld = 1'b1; end
            ST_ROT1: begin
                reg_oe = N'(1) << src_a_q; c_ld = 1'b1;
                c_from_rot = 1'b1; rot_sel = rot_q;
            end
            ST_ADD3, ST_ROT2: begin c_oe = 1'b1; reg_ld = N'(1) << dst_q; end
            ST_LDI1: begin x_oe = 1'b1; reg_ld = N'(1) << dst_q; end
            default: ;
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign imm_out = imm_q;

    // R8: done lasts exactly one cycle.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: done only rises right after a busy step.
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
    // R7: the latched command holds while busy.
    p_hold_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(dst_q) && $stable(src_a_q) && $stable(src_b_q)));
endmodule

// File: rtl/busdp_top.sv
// Single-bus datapath: an N x W register bank, operand latch A, adder,
// rotate-right shifter and result latch C, all joined by one shared bus.
// The bus is built as a one-hot OR-merge. The sequencer keeps it single-driven.
// Assumes: synchronous active-low reset; commands arrive with cmd_valid.
module busdp_top #(
    parameter int DATA_W = 4,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG),
    localparam int ROT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_src_a,
    input  logic [IDX_W-1:0] cmd_src_b,
    input  logic [IDX_W-1:0] cmd_dst,
    input  logic [ROT_W-1:0] cmd_rot,
    input  logic [DATA_W-1:0] cmd_imm,
    input  logic [IDX_W-1:0] rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic             busy,
    output logic             done
);
    logic [NREG-1:0]   reg_oe, reg_ld;
    logic              a_ld, c_ld, c_oe, x_oe, c_from_rot;
    logic [ROT_W-1:0]  rot_sel;
    logic [DATA_W-1:0] imm, bus, reg_drv, rot_out, a_q, c_q;

    busdp_sequencer #(.W(DATA_W), .N(NREG)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst),
        .cmd_rot(cmd_rot), .cmd_imm(cmd_imm),
        .reg_oe(reg_oe), .reg_ld(reg_ld), .a_ld(a_ld), .c_ld(c_ld),
        .c_oe(c_oe), .x_oe(x_oe), .c_from_rot(c_from_rot), .rot_sel(rot_sel),
        .imm_out(imm), .busy(busy), .done(done)
    );

    busdp_regfile #(.W(DATA_W), .N(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .ld(reg_ld), .oe(reg_oe), .bus_in(bus),
        .bus_drv(reg_drv), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    busdp_rotator #(.W(DATA_W)) u_rot (
        .din(bus), .sel(rot_sel), .dout(rot_out)
    );

    // Shared bus: the enabled register, latch C or the immediate.
    assign bus = reg_drv
               | (c_oe ? c_q : '0)
               | (x_oe ? imm : '0);

    // Operand latch A: capture the bus on its load step.
    always_ff @(posedge clk) begin
        if (!rst_n)    a_q <= '0;
        else if (a_ld) a_q <= bus;
    end

    // Result latch C: take the rotated bus or the sum A + bus, keeping the low bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)    c_q <= '0;
        else if (c_ld) c_q <= c_from_rot ? rot_out : DATA_W'(a_q + bus);
    end

    // R10: at most one bus driver in any step.
    p_one_driver_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_oe, c_oe, x_oe}));
    // R3: an add step leaves A plus the bus, mod 2^DATA_W, in C.
    p_add_into_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ld && !c_from_rot) |=> (c_q == DATA_W'($past(a_q) + $past(bus))));
    // R4: a rotate keeps the number of set bits.
    p_rot_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ld && c_from_rot) |=> ($countones(c_q) == $past($countones(bus))));
endmodule

// File: tb/tb_busdp_top.sv
module tb_busdp_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [2:0] cmd_src_a = '0, cmd_src_b = '0, cmd_dst = '0, rd_sel = '0;
    logic [1:0] cmd_rot = '0;
    logic [3:0] cmd_imm = '0;
    logic [3:0] rd_data;
    logic       busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] exp_r [8];

    busdp_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst),
        .cmd_rot(cmd_rot), .cmd_imm(cmd_imm), .rd_sel(rd_sel),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    always #5ns clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] rotr(input logic [3:0] x, input int s);
        logic [7:0] d;
        d = {x, x} >> s;
        return d[3:0];
    endfunction

    // Compare every register with the model.
    task automatic check_regs(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #1;
            check(req, int'(rd_data), int'(exp_r[i]));
        end
    endtask

    // Present a command for one cycle, count the busy cycles, check done.
    task automatic issue(input logic [1:0] op, input int a, input int b, input int d,
                         input int rot, input int imm, input int exp_busy, input string req);
        int n = 0;
        @(negedge clk);
        cmd_op = op; cmd_src_a = 3'(a); cmd_src_b = 3'(b); cmd_dst = 3'(d);
        cmd_rot = 2'(rot); cmd_imm = 4'(imm); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy && n < 20) begin n++; @(negedge clk); end
        check({req, " busy cycles"}, n, exp_busy);
        check("R8 done after last step", int'(done), 1);
        @(negedge clk);
        check("R8 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check_regs("R1 regs");
    endtask

    task automatic t_load;
        int vals [8] = '{4'h3, 4'h9, 4'h8, 4'h5, 4'hC, 4'h1, 4'hA, 4'h7};
        for (int i = 0; i < 8; i++) begin
            issue(2'd2, 0, 0, i, 0, vals[i], 1, "R2");
            exp_r[i] = 4'(vals[i]);
            check_regs("R2 R6 load");
        end
    endtask

    task automatic t_add;
        issue(2'd0, 0, 3, 4, 0, 0, 3, "R3");     // 3 + 5 = 8
        exp_r[4] = exp_r[0] + exp_r[3];
        check_regs("R3 R6 add");
        issue(2'd0, 1, 2, 6, 0, 0, 3, "R3");     // 9 + 8 wraps to 1
        exp_r[6] = exp_r[1] + exp_r[2];
        check("R3 wrap", int'(exp_r[6]), 1);
        check_regs("R3 R6 add wrap");
    endtask

    task automatic t_rotate;
        for (int s = 0; s < 4; s++) begin
            issue(2'd1, 7, 0, 5, s, 0, 2, "R5");
            exp_r[5] = rotr(exp_r[7], s);
            check_regs("R4 rotate");
        end
        rd_sel = 3'd5;
        #1;
        check("R4 sel3 of 0111", int'(rd_data), 4'hE);
    endtask

    task automatic t_self;
        issue(2'd0, 3, 3, 3, 0, 0, 3, "R11");
        exp_r[3] = exp_r[3] + exp_r[3];
        check_regs("R11 self add");
    endtask

    task automatic t_busy_ignore;
        int n = 0;
        @(negedge clk);
        cmd_op = 2'd0; cmd_src_a = 3'd0; cmd_src_b = 3'd1; cmd_dst = 3'd2;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 2'd2; cmd_dst = 3'd7; cmd_imm = 4'hF;  // during busy: ignored
        while (busy && n < 20) begin n++; @(negedge clk); end
        cmd_valid = 1'b0;
        check("R7 busy cycles", n, 3);
        @(negedge clk);
        exp_r[2] = exp_r[0] + exp_r[1];
        check_regs("R7 ignore while busy");
    endtask

    task automatic t_reserved;
        @(negedge clk);
        cmd_op = 2'd3; cmd_dst = 3'd0; cmd_imm = 4'hF; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 busy", int'(busy), 0);
        @(negedge clk);
        check("R9 done", int'(done), 0);
        check_regs("R9 reserved");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_r[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_add();
        t_rotate();
        t_self();
        t_busy_ignore();
        t_reserved();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100us;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule